// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Generator

This block produces two independent pulse-width-modulated outputs from its own module clock. Each channel divides that clock by a coded ratio. The divided ticks drive a counter, and the counter sets the length of each output period and the number of ticks that the output spends at its active level. Software programs the block through a plain 32-bit word-addressed register port. One shared control word holds a 10-bit field per channel, and each channel has its own period/duty word.

A new period/duty value goes into a shadow copy. A running channel takes that copy only when its current period ends, so no truncated period ever appears on the pin. A read-only flag for each channel shows that a value is still waiting to be taken. The divide code is also protected. It is taken only while the channel's clock-gate bit is off, so a running waveform never sees its tick rate change in the middle of a period. A bypass bit sends the raw module clock straight to the pin and overrides every other setting.

Top module: `pwmx_dual`

## Requirements
- R1: After reset, every register reads zero. Both pins sit at the inactive level of the default active-low setting, which is logic 1.
- R2: The control word sits at byte offset 0x0, and the period/duty word of channel n sits at 0x4+4n. The field of channel n starts at bit 15n. In that field, bits 3:0 are the divide code, bit 4 is enable, bit 5 is active level, bit 6 is clock gate, bits 7 and 8 are two spare mode bits that are only stored and read back, and bit 9 is bypass. Bit 28+n of the control word is the read-only ready flag. All other control bits read zero. A write with address bits 1:0 not zero is ignored, and an unmapped offset reads zero.
- R3: With divide code 15 (divide by one), a running channel repeats a period of P+1 clock cycles, where P is bits 31:16 of its period/duty word. The pin is active for the first D cycles of each period, where D is bits 15:0. The first period starts in the cycle after the write that starts the channel.
- R4: With active level 1, the pin is high while active and low otherwise. With active level 0, both levels are inverted.
- R5: A duty count that is greater than or equal to P+1 gives a pin that is always active. A duty count of 0 gives a pin that is always inactive.
- R6: A channel runs only when both enable and clock gate are set. Otherwise its pin is inactive, and its counters restart from zero when it next runs.
- R7: Divide codes 0 to 4 give ratios of 120, 180, 240, 360 and 480. Codes 8 to 12 give 12000, 24000, 36000, 48000 and 72000. Code 15 gives 1. Each counter step lasts exactly one ratio of cycles.
- R8: Divide codes 5, 6, 7, 13 and 14 are invalid. A channel whose taken code is invalid stays stopped, with its pin inactive.
- R9: The divide code in use is updated only by a control write that arrives while the channel's stored clock-gate bit is 0. A code written while the gate is 1 reads back at once but has no effect until the gate is cleared and then set again.
- R10: A period/duty write reads back at once. A running channel takes the new value at the end of its current period, and a stopped channel takes it in the next cycle. The ready flag reads 1 from the write until the value is taken.
- R11: While bypass is set, the pin follows the module clock, whatever the state of the other bits.
- R12: The two channels are independent. Programming one channel does not disturb the other channel's pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; it is also the source that the channels divide |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | 2 | Output pins, one per channel |

## Verification
The hardest case to produce is a period/duty update that arrives in the middle of a running period. From the ports it must be shown that the old period runs to its end, and that the new value, not a blend of the two, starts at the next boundary. The stimulus starts a channel at a known counter phase and writes the new word two cycles later. It then compares each later cycle with a sequence worked out by hand, reading the ready flag while the value is pending and again after it has been taken. A second hard case is a divide-code change while the gate is on. The bench shows that the waveform keeps toggling every cycle, and only after the gate is turned off and on again does it slow to 120-cycle steps.

// File: rtl/pwmx_pkg.sv
// Package: shared field layout, register geometry and divide-code decoding
// for the two-channel pulse-width generator. Assumes a 4-bit divide code.
package pwmx_pkg;

    localparam int FIELD_W      = 10;  // bits per channel control field
    localparam int FIELD_STRIDE = 15;  // bit distance between channel fields
    localparam int READY_BASE   = 28;  // bit of channel 0 ready flag
    localparam int CODE_W       = 4;
    localparam int DIV_W        = 17;  // wide enough for the largest ratio

    typedef struct packed {
        logic              byp;    // bit 9
        logic              spare1; // bit 8, stored only
        logic              spare0; // bit 7, stored only
        logic              gate;   // bit 6
        logic              lvl;    // bit 5
        logic              en;     // bit 4
        logic [CODE_W-1:0] code;   // bits 3:0
    } chan_ctrl_t;

    // Map a divide code to its ratio; zero marks an invalid code.
    function automatic logic [DIV_W-1:0] code_to_div(input logic [CODE_W-1:0] c);
        logic [DIV_W-1:0] r;
        case (c)
            4'd0:    r = DIV_W'(120);
            4'd1:    r = DIV_W'(180);
            4'd2:    r = DIV_W'(240);
            4'd3:    r = DIV_W'(360);
            4'd4:    r = DIV_W'(480);
            4'd8:    r = DIV_W'(12000);
            4'd9:    r = DIV_W'(24000);
            4'd10:   r = DIV_W'(36000);
            4'd11:   r = DIV_W'(48000);
            4'd12:   r = DIV_W'(72000);
            4'd15:   r = DIV_W'(1);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwmx_prescale.sv
// Tick divider: emits one tick every div cycles while clear is low.
// Assumes div is held stable while clear is low; div of zero gives no ticks.
module pwmx_prescale #(
    parameter int DIV_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] pc;

    // Tick when the phase counter reaches the last cycle of a step.
    assign tick = !clear && (div != '0) && (pc == div - 1'b1);

    // Phase counter: held at zero while cleared, wraps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pc <= '0;
        end else if (tick) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    // A ratio above one never gives two ticks in a row.
    assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div > DIV_W'(1) && !clear) |=> !tick);

endmodule

// File: rtl/pwmx_channel.sv
// One output channel: control field, shadowed period/duty word, divide-code
// capture, period counter and pin drive. Assumes the module clock is also
// the source that is divided and that bypass may put it on the pin.
module pwmx_channel
    import pwmx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_we,
    input  chan_ctrl_t           wr_field,
    input  logic                 prd_we,
    input  logic [2*CNT_W-1:0]   prd_wdata,
    output chan_ctrl_t           fld,
    output logic [2*CNT_W-1:0]   prd_shadow,
    output logic                 pending,
    output logic                 pin
);

    logic [CODE_W-1:0]  code_eff;
    logic [2*CNT_W-1:0] cur;
    logic [CNT_W-1:0]   cnt;
    logic [DIV_W-1:0]   div;
    logic [CNT_W-1:0]   prd_cur;
    logic [CNT_W-1:0]   duty_cur;
    logic               run;
    logic               tick;
    logic               wrap;
    logic               load;
    logic               active;

    assign prd_cur  = cur[2*CNT_W-1:CNT_W];
    assign duty_cur = cur[CNT_W-1:0];
    assign div      = code_to_div(code_eff);
    assign run      = fld.en && fld.gate && (div != '0);
    assign wrap     = run && tick && (cnt >= prd_cur);
    assign load     = pending && (!run || wrap);
    assign active   = run && (cnt < duty_cur);

    // Control field register, written from the shared control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld <= '0;
        end else if (ctrl_we) begin
            fld <= wr_field;
        end
    end

    // Divide code in use: taken only while the stored gate bit is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_eff <= '0;
        end else if (ctrl_we && !fld.gate) begin
            code_eff <= wr_field.code;
        end
    end

    // Shadow, pending flag and working copy of the period/duty word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_shadow <= '0;
            pending    <= 1'b0;
            cur        <= '0;
        end else begin
            if (load) begin
                cur <= prd_shadow;
            end
            if (prd_we) begin
                prd_shadow <= prd_wdata;
                pending    <= 1'b1;
            end else if (load) begin
                pending <= 1'b0;
            end
        end
    end

    // Period counter: steps on each tick, restarts at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt >= prd_cur) ? '0 : cnt + 1'b1;
        end
    end

    pwmx_prescale #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!run),
        .div   (div),
        .tick  (tick)
    );

    // Pin drive: raw clock in bypass, else the level chosen by the counter.
    always_comb begin
        if (fld.byp) begin
            pin = clk;
        end else begin
            pin = active ? fld.lvl : !fld.lvl;
        end
    end

    // The counter never passes the period limit while running.
    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= prd_cur));

    // The working copy changes only at a period end or while stopped.
    assert_load_on_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur) |-> $past(!run || wrap));

    // A stopped channel takes a pending value in the next cycle.
    assert_ready_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !run && !prd_we) |=> !pending);

    // The code in use stays put while the gate stays on.
    assert_code_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fld.gate && $past(fld.gate)) |-> $stable(code_eff));

    // A stopped channel restarts its period count from zero.
    assert_stop_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/pwmx_dual.sv
// Top: register port decode, read-back assembly and the channel array.
// Assumes word-aligned accesses; 15-bit field spacing fits two channels
// below the ready flags.
module pwmx_dual
    import pwmx_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NCH-1:0]    pwm_out
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int PRD_W  = 2 * CNT_W;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              ctrl_we;
    logic [NCH-1:0]    prd_we;
    logic [NCH-1:0]    pend;
    chan_ctrl_t        fld    [NCH];
    logic [PRD_W-1:0]  shadow [NCH];

    assign word    = reg_addr[ADDR_W-1:2];
    assign aligned = (reg_addr[1:0] == 2'b00);
    assign ctrl_we = reg_we && aligned && (word == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign prd_we[g] = reg_we && aligned && (word == WORD_W'(g + 1));

        pwmx_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_we    (ctrl_we),
            .wr_field   (chan_ctrl_t'(reg_wdata[g*FIELD_STRIDE +: FIELD_W])),
            .prd_we     (prd_we[g]),
            .prd_wdata  (reg_wdata[PRD_W-1:0]),
            .fld        (fld[g]),
            .prd_shadow (shadow[g]),
            .pending    (pend[g]),
            .pin        (pwm_out[g])
        );
    end

    // Read-back: control word with ready flags, or one period/duty word.
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            if (word == '0) begin
                for (int n = 0; n < NCH; n++) begin
                    reg_rdata[n*FIELD_STRIDE +: FIELD_W] = fld[n];
                    reg_rdata[READY_BASE + n]            = pend[n];
                end
            end else begin
                for (int n = 0; n < NCH; n++) begin
                    if (word == WORD_W'(n + 1)) begin
                        reg_rdata = 32'(shadow[n]);
                    end
                end
            end
        end
    end

endmodule

// File: tb/tb_pwmx_dual.sv
`timescale 1ns/1ps
module tb_pwmx_dual;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pwm_out;

    int checks = 0;
    int fails  = 0;

    pwmx_dual dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    // Vectors: channel, code, period-1, duty, level, samples, requirement
    localparam int NV = 8;
    localparam int VEC [NV][7] = '{
        '{0, 15, 3, 2, 1,   16, 3},
        '{0, 15, 4, 1, 0,   15, 4},
        '{0, 15, 2, 3, 1,    9, 5},
        '{0, 15, 5, 0, 1,   12, 5},
        '{1, 15, 2, 1, 1,   12, 12},
        '{1, 15, 0, 1, 0,    5, 5},
        '{0,  0, 1, 1, 1,  480, 7},
        '{1,  3, 2, 2, 1, 1100, 7}
    };

    function automatic string tag(int r);
        case (r)
            3: return "R3";
            4: return "R4";
            5: return "R5";
            7: return "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = '0;
    endtask

    task automatic rd_check(string req, logic [3:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
        reg_addr = '0;
    endtask

    function automatic logic [31:0] cw(int ch, int code, int en, int lvl, int gate, int byp);
        logic [31:0] f;
        f = 32'(code & 15) | (32'(en) << 4) | (32'(lvl) << 5) | (32'(gate) << 6) | (32'(byp) << 9);
        return f << (15 * ch);
    endfunction

    function automatic int div_of(int code);
        case (code)
            0: return 120;  1: return 180;  2: return 240;  3: return 360;  4: return 480;
            8: return 12000; 9: return 24000; 10: return 36000; 11: return 48000; 12: return 72000;
            15: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic exp_pin(int k, int code, int prm, int duty, int lvl);
        int c;
        c = (k / div_of(code)) % (prm + 1);
        return (c < duty) ? lvl[0] : !lvl[0];
    endfunction

    task automatic start(int ch, int code, int prm, int duty, int lvl);
        wr(4'h0, 32'h0);
        wr(4'(4 + 4 * ch), {prm[15:0], duty[15:0]});
        wr(4'h0, cw(ch, code, 1, lvl, 1, 0));
    endtask

    task automatic idle_check(string req, int ch, logic exp, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            check(req, 32'(pwm_out[ch]), 32'(exp));
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic prev;
        logic [15:0] seq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", 32'(pwm_out), 32'h3);
        rd_check("R1", 4'h0, 32'h0);
        rd_check("R1", 4'h4, 32'h0);
        rd_check("R1", 4'h8, 32'h0);

        // Vector table: R3 R4 R5 R7 R12
        for (int v = 0; v < NV; v++) begin
            int ch;
            ch = VEC[v][0];
            start(ch, VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
            for (int k = 0; k < VEC[v][5]; k++) begin
                if (k > 0) @(negedge clk);
                #1;
                check(tag(VEC[v][6]), 32'(pwm_out[ch]),
                      32'(exp_pin(k, VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4])));
                check("R12", 32'(pwm_out[1-ch]), 32'h1);
            end
        end

        // R10: mid-period update taken at the period end
        start(0, 15, 3, 2, 1);
        #1; check("R3", 32'(pwm_out[0]), 32'h1);
        wr(4'h4, {16'd7, 16'd1});
        seq = 16'b0000_0100_0000_0100; // bit j: expected pin at sample j
        for (int j = 0; j < 12; j++) begin
            if (j > 0) @(negedge clk);
            #1;
            check("R10", 32'(pwm_out[0]), 32'(seq[j]));
            if (j == 0 || j == 1) check("R10", 32'(reg_rdata[28]), 32'h1);
            if (j == 2) check("R10", 32'(reg_rdata[28]), 32'h0);
        end
        rd_check("R10", 4'h4, 32'h0007_0001);

        // R10: stopped channel 1 takes its value the next cycle
        wr(4'h0, 32'h0);
        wr(4'h8, {16'd2, 16'd1});
        #1; check("R10", 32'(reg_rdata[29]), 32'h1);
        @(negedge clk); #1;
        check("R10", 32'(reg_rdata[29]), 32'h0);

        // R9: code change while gated on has no effect until regated
        start(0, 15, 1, 1, 1);
        wr(4'h0, cw(0, 0, 1, 1, 1, 0));
        #1; prev = pwm_out[0];
        check("R9", reg_rdata & 32'hF, 32'h0);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk); #1;
            check("R9", 32'(pwm_out[0]), 32'(!prev));
            prev = pwm_out[0];
        end
        wr(4'h0, cw(0, 0, 1, 1, 0, 0));
        wr(4'h0, cw(0, 0, 1, 1, 1, 0));
        for (int k = 0; k < 240; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            check("R9", 32'(pwm_out[0]), 32'(exp_pin(k, 0, 1, 1, 1)));
        end

        // R6: enable or gate alone keeps the pin inactive
        wr(4'h0, 32'h0);
        wr(4'h4, {16'd3, 16'd4});
        wr(4'h0, cw(0, 15, 1, 1, 0, 0));
        idle_check("R6", 0, 1'b0, 4);
        wr(4'h0, cw(0, 15, 0, 1, 1, 0));
        idle_check("R6", 0, 1'b0, 4);
        wr(4'h0, cw(0, 15, 1, 1, 1, 0));
        idle_check("R6", 0, 1'b1, 4);

        // R8: invalid codes keep the channel stopped
        wr(4'h0, cw(0, 15, 1, 1, 0, 0));
        wr(4'h0, cw(0, 5, 1, 1, 1, 0));
        idle_check("R8", 0, 1'b0, 4);
        wr(4'h0, cw(0, 13, 1, 1, 0, 0));
        wr(4'h0, cw(0, 13, 1, 1, 1, 0));
        idle_check("R8", 0, 1'b0, 4);

        // R11: bypass passes the clock through
        wr(4'h0, 32'h0);
        wr(4'h0, cw(1, 0, 0, 0, 0, 1));
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #2;
            check("R11", 32'(pwm_out[1]), 32'h1);
            @(negedge clk); #2;
            check("R11", 32'(pwm_out[1]), 32'h0);
            check("R12", 32'(pwm_out[0]), 32'h1);
        end

        // R2: map, reserved bits and ignored accesses
        wr(4'h0, 32'h0);
        wr(4'h8, 32'hA5A5_5A5A);
        wr(4'h0, 32'hFFFF_FFFF);
        rd_check("R2", 4'h0, 32'h01FF_83FF);
        rd_check("R2", 4'h8, 32'hA5A5_5A5A);
        rd_check("R2", 4'hC, 32'h0);
        wr(4'h9, 32'h1234_5678);
        rd_check("R2", 4'h8, 32'hA5A5_5A5A);
        rd_check("R2", 4'h9, 32'h0);
        wr(4'h0, 32'h0);

        summary();
        $finish;
    end

endmodule